// File: doc/BRIEF.md
# Dual-Rail Threshold-Gate Half Adder

This block adds two one-bit operands encoded on mutually exclusive wire pairs and returns sum and carry in the same encoding. A logical 0 is signalled by raising the pair's 0-wire, a logical 1 by raising its 1-wire, and a pair with neither wire raised carries no value (the spacer state). The block is driven in alternating wavefronts. A full data wavefront gives each operand pair exactly one raised wire. A spacer wavefront brings every input wire low. Consecutive data wavefronts must always be separated by a spacer.

Four two-input threshold cells compute the result, one cell for each operand combination. Each cell fires only when both of its inputs are high. It then holds its output until both inputs are low again. The cells are modelled as clocked state elements with a synchronous active-high reset, so a synchronous environment can step wavefronts through the block one clock at a time. Completion detectors report when the operand pairs are complete and when the result pairs are complete. A protocol-error flag reports an operand pair with both wires raised.

Top module: `ncl_half_adder`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all result wires, `in_done`, `out_done` and `proto_err` are 0.
- R2: Wire 0 of a pair means logical 0 and wire 1 means logical 1. One clock edge after both operand pairs become complete, the sum pair carries A XOR B and the carry pair carries A AND B, each with exactly one wire high.
- R3: A threshold cell fires only when both of its inputs are high. If only one operand pair holds a value, all four result wires stay 0.
- R4: With legal operands, at most one threshold cell is high at a time, and neither result pair ever has both wires high.
- R5: A fired cell holds its result while any of its inputs is still high. All result wires return to 0 one edge after every input wire is 0.
- R6: `out_done` rises one edge after both result pairs each hold exactly one high wire. It falls one edge after all four result wires are 0. In between it holds.
- R7: `in_done` rises one edge after both operand pairs are complete. It holds while the operands are only partly returned to spacer, and falls one edge after all four input wires are 0.
- R8: `proto_err` is high on the cycle after an operand pair has both wires high, and low one edge after that condition clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that steps the modelled threshold cells |
| rst | input | 1 | Synchronous active-high reset |
| a_r0 | input | 1 | Operand A, logical-0 wire |
| a_r1 | input | 1 | Operand A, logical-1 wire |
| b_r0 | input | 1 | Operand B, logical-0 wire |
| b_r1 | input | 1 | Operand B, logical-1 wire |
| sum_r0 | output | 1 | Sum, logical-0 wire |
| sum_r1 | output | 1 | Sum, logical-1 wire |
| cry_r0 | output | 1 | Carry, logical-0 wire |
| cry_r1 | output | 1 | Carry, logical-1 wire |
| in_done | output | 1 | Operand completion, with hysteresis |
| out_done | output | 1 | Result completion, with hysteresis |
| proto_err | output | 1 | Both wires of an operand pair were high |

## Verification
The assertions check three things on every cycle. Each threshold cell obeys its set, hold and clear rule. Each completion register moves only on a full pair set or a full spacer, and otherwise holds. While the operands have stayed legal since reset, neither result pair shows both wires and only one cell is high at a time. Only the bench scenarios can show that the decoded sum and carry are arithmetically correct for all four operand combinations. The same holds for the exact latency of one edge to the result and two edges to `out_done`, for a half-presented operand producing nothing, for the result holding through a partial spacer, and for the error flag's timing.

// File: rtl/ncl_ha_pkg.sv
package ncl_ha_pkg;
  // wires per encoded bit
  localparam int RAILS = 2;
  // operand groups feeding the adder
  localparam int OPERANDS = 2;
  // one threshold cell per operand combination
  localparam int COMBOS = RAILS ** OPERANDS;
  // result groups: sum and carry
  localparam int RESULTS = 2;

  typedef struct packed {
    logic r1;
    logic r0;
  } pair_t;

  function automatic logic pair_valid(input pair_t p);
    return p.r1 ^ p.r0;
  endfunction

  function automatic logic pair_clash(input pair_t p);
    return p.r1 & p.r0;
  endfunction
endpackage

// File: rtl/ncl_th_cell.sv
module ncl_th_cell #(
  parameter int N_IN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] ins,
  output logic            q
);
  logic all_hi;
  logic all_lo;

  assign all_hi = &ins;
  assign all_lo = ~(|ins);

  always_ff @(posedge clk) begin
    if (rst)         q <= 1'b0;
    else if (all_hi) q <= 1'b1;
    else if (all_lo) q <= 1'b0;
  end

  // R3
  th_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (&ins) |=> q);
  // R5
  th_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q && (|ins)) |=> q);
  // R5
  th_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|ins)) |=> !q);
  // R3
  th_no_early_chk: assert property (@(posedge clk) disable iff (rst)
    (!q && !(&ins)) |=> !q);
endmodule

// File: rtl/ncl_group_detect.sv
module ncl_group_detect
  import ncl_ha_pkg::*;
#(
  parameter int GROUPS = 2
) (
  input  pair_t [GROUPS-1:0] pairs,
  output logic               all_valid,
  output logic               all_null,
  output logic               any_clash
);
  logic [GROUPS-1:0] v;
  logic [GROUPS-1:0] n;
  logic [GROUPS-1:0] c;

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    assign v[k] = pair_valid(pairs[k]);
    assign c[k] = pair_clash(pairs[k]);
    assign n[k] = ~(pairs[k].r0 | pairs[k].r1);
  end

  assign all_valid = &v;
  assign all_null  = &n;
  assign any_clash = |c;
endmodule

// File: rtl/ncl_done_reg.sv
module ncl_done_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);
  // R6
  done_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/ncl_half_adder.sv
module ncl_half_adder
  import ncl_ha_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_r0,
  input  logic a_r1,
  input  logic b_r0,
  input  logic b_r1,
  output logic sum_r0,
  output logic sum_r1,
  output logic cry_r0,
  output logic cry_r1,
  output logic in_done,
  output logic out_done,
  output logic proto_err
);
  pair_t [OPERANDS-1:0] opnd;
  pair_t [RESULTS-1:0]  rslt;
  logic  [COMBOS-1:0]   gate_q;
  logic in_valid, in_null, in_clash;
  logic out_valid, out_null, out_clash;
  logic err_q;
  logic err_seen;

  assign opnd[0] = '{r1: a_r1, r0: a_r0};
  assign opnd[1] = '{r1: b_r1, r0: b_r0};

  // one threshold cell per operand combination; index bit1 = A value, bit0 = B value
  for (genvar g = 0; g < COMBOS; g++) begin : g_th
    localparam int AV = (g >> 1) & 1;
    localparam int BV = g & 1;
    logic [OPERANDS-1:0] sel;
    assign sel[0] = (AV != 0) ? opnd[0].r1 : opnd[0].r0;
    assign sel[1] = (BV != 0) ? opnd[1].r1 : opnd[1].r0;
    ncl_th_cell #(.N_IN(OPERANDS)) u_th (
      .clk (clk),
      .rst (rst),
      .ins (sel),
      .q   (gate_q[g])
    );
  end

  // OR network: each combination drives the sum wire of a XOR b and the carry wire of a AND b
  always_comb begin
    rslt = '0;
    for (int g = 0; g < COMBOS; g++) begin
      if ((g[1] ^ g[0]) != 1'b0) rslt[0].r1 = rslt[0].r1 | gate_q[g];
      else                       rslt[0].r0 = rslt[0].r0 | gate_q[g];
      if ((g[1] & g[0]) != 1'b0) rslt[1].r1 = rslt[1].r1 | gate_q[g];
      else                       rslt[1].r0 = rslt[1].r0 | gate_q[g];
    end
  end

  ncl_group_detect #(.GROUPS(OPERANDS)) u_in_det (
    .pairs     (opnd),
    .all_valid (in_valid),
    .all_null  (in_null),
    .any_clash (in_clash)
  );

  ncl_group_detect #(.GROUPS(RESULTS)) u_out_det (
    .pairs     (rslt),
    .all_valid (out_valid),
    .all_null  (out_null),
    .any_clash (out_clash)
  );

  ncl_done_reg u_in_done (
    .clk   (clk),
    .rst   (rst),
    .set_i (in_valid),
    .clr_i (in_null),
    .q     (in_done)
  );

  ncl_done_reg u_out_done (
    .clk   (clk),
    .rst   (rst),
    .set_i (out_valid),
    .clr_i (out_null),
    .q     (out_done)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= in_clash;
  end

  // checker-only history: illegal operands void the exclusivity guarantees
  always_ff @(posedge clk) begin
    if (rst)           err_seen <= 1'b0;
    else if (in_clash) err_seen <= 1'b1;
  end

  assign sum_r0    = rslt[0].r0;
  assign sum_r1    = rslt[0].r1;
  assign cry_r0    = rslt[1].r0;
  assign cry_r1    = rslt[1].r1;
  assign proto_err = err_q;

  // R4
  one_gate_chk: assert property (@(posedge clk) disable iff (rst || err_seen || in_clash)
    $onehot0(gate_q));
  // R4
  out_excl_chk: assert property (@(posedge clk) disable iff (rst || err_seen || in_clash)
    !out_clash);
  // R2
  out_from_input_chk: assert property (@(posedge clk) disable iff (rst || err_seen || in_clash)
    (!out_null && !$past(out_null)) |-> $past(!in_null));
  // R8
  err_track_chk: assert property (@(posedge clk) disable iff (rst)
    in_clash |=> proto_err);
endmodule

// File: tb/ncl_half_adder_tb.sv
module ncl_half_adder_tb;
  logic clk = 1'b0;
  logic rst;
  logic a_r0, a_r1, b_r0, b_r1;
  logic sum_r0, sum_r1, cry_r0, cry_r1;
  logic in_done, out_done, proto_err;
  int n_chk = 0;
  int n_bad = 0;

  // entry: {a, b, expected sum, expected carry}
  localparam logic [3:0] VECS [4] = '{4'b0000, 4'b0110, 4'b1010, 4'b1101};

  always #5 clk = ~clk;

  ncl_half_adder u_dut (
    .clk(clk), .rst(rst),
    .a_r0(a_r0), .a_r1(a_r1), .b_r0(b_r0), .b_r1(b_r1),
    .sum_r0(sum_r0), .sum_r1(sum_r1), .cry_r0(cry_r0), .cry_r1(cry_r1),
    .in_done(in_done), .out_done(out_done), .proto_err(proto_err)
  );

  task automatic check(input string req, input string what, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic a0, input logic a1, input logic b0, input logic b1);
    a_r0 = a0; a_r1 = a1; b_r0 = b0; b_r1 = b1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] outs();
    return {cry_r1, cry_r0, sum_r1, sum_r0};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "rails in reset", outs(), 4'b0000);
    check("R1", "flags in reset", {1'b0, in_done, out_done, proto_err}, 4'b0000);
    rst = 1'b0;
    step();
    check("R1", "rails after reset", outs(), 4'b0000);
    check("R1", "flags after reset", {1'b0, in_done, out_done, proto_err}, 4'b0000);

    // table walk: each data wavefront followed by a spacer
    for (int i = 0; i < 4; i++) begin
      logic av, bv, sv, cv;
      {av, bv, sv, cv} = VECS[i];
      drive(!av, av, !bv, bv);
      step();
      // R2 encoding: wire0 = 0, wire1 = 1
      check("R2", "sum/carry rails", outs(), {cv, !cv, sv, !sv});
      check("R7", "in_done rise", {3'b0, in_done}, 4'b0001);
      check("R6", "out_done one edge later", {3'b0, out_done}, 4'b0000);
      step();
      check("R6", "out_done rise", {3'b0, out_done}, 4'b0001);
      check("R4", "rails stay exclusive", outs(), {cv, !cv, sv, !sv});
      drive(0, 0, 0, 0);
      step();
      check("R5", "rails cleared on spacer", outs(), 4'b0000);
      check("R7", "in_done fall", {3'b0, in_done}, 4'b0000);
      check("R6", "out_done held", {3'b0, out_done}, 4'b0001);
      step();
      check("R6", "out_done fall", {3'b0, out_done}, 4'b0000);
    end

    // R3 only one operand present: nothing fires
    drive(0, 1, 0, 0);
    step(); step();
    check("R3", "half operand rails", outs(), 4'b0000);
    check("R3", "half operand done", {2'b0, in_done, out_done}, 4'b0000);
    drive(0, 1, 1, 0);
    step();
    check("R3", "completed operand fires", outs(), 4'b0110);

    // R5 partial spacer: A returns first, result holds
    step();
    drive(0, 0, 1, 0);
    step(); step();
    check("R5", "hold on partial spacer", outs(), 4'b0110);
    check("R7", "in_done holds", {2'b0, in_done, out_done}, 4'b0011);
    drive(0, 0, 0, 0);
    step();
    check("R5", "clear after full spacer", outs(), 4'b0000);
    step();
    check("R6", "out_done low after spacer", {3'b0, out_done}, 4'b0000);

    // R8 both wires of B raised
    drive(0, 0, 1, 1);
    check("R8", "no flag before edge", {3'b0, proto_err}, 4'b0000);
    step();
    check("R8", "flag raised", {3'b0, proto_err}, 4'b0001);
    drive(0, 0, 0, 0);
    step();
    check("R8", "flag cleared", {3'b0, proto_err}, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule